// File: doc/BRIEF.md
# Serial Flash Security Register Controller

This block is the slave side of a serial flash's one-time-programmable security area. It watches an SPI mode-0 link: chip select, serial clock and serial data in. All three are sampled by a faster system clock. The block decodes the commands it sees and drives serial data out. Three register banks of 1024 bytes each sit in internal storage. A bank can be erased to all ones. A bank can also be programmed, which only clears bits, so the stored value becomes the AND of the old data and the new data. A bank can be read back. A status byte can be polled at any time.

Every modifying command needs two things. The write-enable latch must have been set beforehand, and the addressed bank must not be locked. A modifying command is carried out only when chip select rises. It then starts a self-timed busy period, and its length is counted in system clocks. While that period runs, the write-in-progress flag is set and only the status command is answered. The write-enable latch is cleared when the busy period ends. The lock bits are loaded from a configuration input at reset and cannot be changed afterwards.

Top module: `sreg_ctrl`

## Requirements
- R1: After reset the write-enable latch and write-in-progress flag are 0, so the status byte reads 0x00. The lock bit of register n (n = 1..3) is taken from bit n-1 of `cfg_lock` while reset is high.
- R2: Opcode 0x06 sets the write-enable latch at the chip-select rise, provided the rise falls on a byte boundary. Opcode 0x05 returns the status byte on every byte that follows it: bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7:2 are 0.
- R3: Every command is followed by a 24-bit address, sent MSB first. Bits 23:16 must be 0x00 and bits 11:10 must be 00. Bits 15:12 equal to 1, 2 or 3 select register 1, 2 or 3, and bits 9:0 are the byte offset. Any other address turns the command into a no-op that leaves the write-enable latch unchanged.
- R4: If the write-enable latch is 0, an erase (0x44) or program (0x42) command has no effect and no busy period starts.
- R5: The busy period starts only at the chip-select rise. An erase is discarded unless chip select rises exactly after the opcode and three address bytes, on a byte boundary.
- R6: An erase sets all 1024 bytes of the selected register to 0xFF.
- R7: A program writes each complete data byte as the AND of the stored byte and the new byte, at consecutive offsets that wrap within the register. At least one complete data byte is needed for the busy period to start. Trailing bits that do not make a full byte are dropped.
- R8: Write-in-progress reads 1 from the start of the busy period until ERASE_CYC (for an erase) or PROG_CYC (for a program) system clocks have passed, then 0. The write-enable latch is 0 once the period ends.
- R9: When the addressed register's lock bit is 1, erase and program commands to it are ignored and the write-enable latch is left unchanged.
- R10: While write-in-progress is 1, every command except 0x05 is ignored. A read returns 0x00, and a write-enable or program command changes nothing.
- R11: Opcode 0x48 followed by an address returns the stored bytes starting at the offset, advancing and wrapping within the register. An invalid address returns 0x00 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lock | input | NUM_REGS | Lock bits, captured while reset is high |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data in, sampled on the rising edge of the serial clock |
| spi_miso | output | 1 | Serial data out, updated after the falling edge of the serial clock |

## Verification
Internal state can only be seen through the status byte and read-back. A latch or lock that is wrong appears in the first status poll after the command's chip-select rise: the poll shows either a busy flag that should not be there or a write-enable bit that has changed. Damage to a bank's contents, such as a wrong offset, a wrong wrap, a lost AND, or the wrong bank erased, shows only when that area is read back. For that reason every program is followed by a read of the bytes around it, compared against a model held in the bench. A busy count that is wrong shows as write-in-progress still set, or already clear, at a poll placed inside or just after the expected period.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int OFFS_W    = 10;
    localparam int REG_BYTES = 1 << OFFS_W;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_PROG  = 8'h42;
    localparam logic [7:0] OP_ERASE = 8'h44;
    localparam logic [7:0] OP_READ  = 8'h48;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_RDSR,
        CMD_PROG,
        CMD_ERASE,
        CMD_READ
    } cmd_e;

    typedef struct packed {
        logic       ok;
        logic [3:0] sel;
    } loc_t;

    function automatic cmd_e op_decode(input logic [7:0] op);
        case (op)
            OP_WREN:  return CMD_WREN;
            OP_RDSR:  return CMD_RDSR;
            OP_PROG:  return CMD_PROG;
            OP_ERASE: return CMD_ERASE;
            OP_READ:  return CMD_READ;
            default:  return CMD_NONE;
        endcase
    endfunction

    // Bank select in bits 15:12 (1-based), high byte and bits 11:10 must be zero.
    function automatic loc_t loc_decode(input logic [23:0] a, input int nregs);
        loc_t l;
        l.sel = a[15:12] - 4'd1;
        l.ok  = (a[23:16] == 8'h00) && (a[11:10] == 2'b00) &&
                (a[15:12] != 4'd0) && (int'(a[15:12]) <= nregs);
        return l;
    endfunction

    function automatic logic [7:0] status_byte(input logic wel, input logic wip);
        return {6'b0, wel, wip};
    endfunction

endpackage

// File: rtl/sreg_spi_if.sv
module sreg_spi_if (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_csn,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    input  logic [7:0] tx_byte,
    output logic       active,
    output logic       cs_rise,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic [2:0] bit_idx,
    output logic       tx_load,
    output logic       spi_miso
);
    logic [2:0] csn_s;
    logic [2:0] sck_s;
    logic [1:0] mosi_s;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;
    logic       sck_rise;
    logic       sck_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_s  <= 3'b111;
            sck_s  <= 3'b000;
            mosi_s <= 2'b00;
        end else begin
            csn_s  <= {csn_s[1:0], spi_csn};
            sck_s  <= {sck_s[1:0], spi_sck};
            mosi_s <= {mosi_s[0], spi_mosi};
        end
    end

    assign active   = ~csn_s[1];
    assign cs_rise  = csn_s[1] & ~csn_s[2];
    assign sck_rise = sck_s[1] & ~sck_s[2];
    assign sck_fall = ~sck_s[1] & sck_s[2];

    assign byte_done = active && sck_rise && (bit_idx == 3'd7);
    assign rx_byte   = {rx_sr, mosi_s[1]};
    assign tx_load   = active && sck_fall && (bit_idx == 3'd0);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_idx <= 3'd0;
            rx_sr   <= 7'd0;
            tx_sr   <= 8'd0;
        end else begin
            if (sck_rise) begin
                rx_sr   <= rx_byte[6:0];
                bit_idx <= bit_idx + 3'd1;
            end
            if (sck_fall) begin
                tx_sr <= (bit_idx == 3'd0) ? tx_byte : {tx_sr[6:0], 1'b0};
            end
        end
    end

    assign spi_miso = active & tx_sr[7];

endmodule

// File: rtl/sreg_array.sv
module sreg_array
    import sreg_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter int SEL_W    = 2
) (
    input  logic              clk,
    input  logic              erase_en,
    input  logic [SEL_W-1:0]  erase_sel,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [OFFS_W-1:0] wr_offs,
    input  logic [7:0]        wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [OFFS_W-1:0] rd_offs,
    output logic [7:0]        rd_data
);
    logic [7:0] rd_bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
        logic [7:0] bank [REG_BYTES];

        always_ff @(posedge clk) begin
            if (erase_en && (erase_sel == SEL_W'(g))) begin
                for (int i = 0; i < REG_BYTES; i++) bank[i] <= 8'hFF;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                bank[wr_offs] <= bank[wr_offs] & wr_data;
            end
        end

        assign rd_bank[g] = bank[rd_offs];
    end

    always_comb begin
        rd_data = 8'h00;
        for (int g = 0; g < NUM_REGS; g++) begin
            if (rd_sel == SEL_W'(g)) rd_data = rd_bank[g];
        end
    end

endmodule

// File: rtl/sreg_busy.sv
module sreg_busy #(
    parameter int ERASE_CYC = 2000,
    parameter int PROG_CYC  = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic start_erase,
    input  logic start_prog,
    output logic busy,
    output logic done
);
    localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (start_erase)   cnt <= CNT_W'(ERASE_CYC);
        else if (start_prog)    cnt <= CNT_W'(PROG_CYC);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
    import sreg_pkg::*;
#(
    parameter int NUM_REGS  = 3,
    parameter int ERASE_CYC = 2000,
    parameter int PROG_CYC  = 500
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] cfg_lock,
    input  logic                spi_csn,
    input  logic                spi_sck,
    input  logic                spi_mosi,
    output logic                spi_miso
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              active, cs_rise, byte_done, tx_load;
    logic [7:0]        rx_byte, tx_byte, rd_data;
    logic [2:0]        bit_idx;
    cmd_e              cmd;
    logic [2:0]        byte_cnt;
    logic [23:0]       addr_q;
    logic [OFFS_W-1:0] ptr;
    logic              got_data;
    logic              wel, wip, busy_done;
    logic [NUM_REGS-1:0] lock;
    loc_t              loc;
    logic [SEL_W-1:0]  sel;
    logic              addr_done, lock_hit, may_write, may_read;
    logic              prog_we, erase_go, prog_go, wren_go, rd_adv;

    sreg_spi_if u_if (
        .clk(clk), .rst(rst),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .tx_byte(tx_byte), .active(active), .cs_rise(cs_rise),
        .byte_done(byte_done), .rx_byte(rx_byte), .bit_idx(bit_idx),
        .tx_load(tx_load), .spi_miso(spi_miso)
    );

    assign loc       = loc_decode(addr_q, NUM_REGS);
    assign sel       = loc.sel[SEL_W-1:0];
    assign addr_done = (byte_cnt >= 3'd4);
    assign lock_hit  = |(lock & (NUM_REGS'(1) << loc.sel));
    assign may_write = addr_done && loc.ok && wel && !wip && !lock_hit;
    assign may_read  = addr_done && loc.ok && !wip;

    assign prog_we  = byte_done && (cmd == CMD_PROG) && may_write;
    assign erase_go = cs_rise && (cmd == CMD_ERASE) && (byte_cnt == 3'd4) &&
                      (bit_idx == 3'd0) && may_write;
    assign prog_go  = cs_rise && (cmd == CMD_PROG) && got_data && may_write;
    assign wren_go  = cs_rise && (cmd == CMD_WREN) && (bit_idx == 3'd0) && !wip;
    assign rd_adv   = tx_load && (cmd == CMD_READ) && may_read;

    always_comb begin
        if (cmd == CMD_RDSR)                     tx_byte = status_byte(wel, wip);
        else if ((cmd == CMD_READ) && may_read)  tx_byte = rd_data;
        else                                     tx_byte = 8'h00;
    end

    // Per-transaction command tracking; cleared while chip select is high.
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cmd      <= CMD_NONE;
            byte_cnt <= 3'd0;
            got_data <= 1'b0;
        end else if (byte_done) begin
            if (byte_cnt != 3'd5) byte_cnt <= byte_cnt + 3'd1;
            if (byte_cnt == 3'd0) cmd <= op_decode(rx_byte);
            if (prog_we)          got_data <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= 24'd0;
            ptr    <= '0;
        end else begin
            if (byte_done && (byte_cnt != 3'd0) && (byte_cnt <= 3'd3))
                addr_q <= {addr_q[15:0], rx_byte};
            if (byte_done && (byte_cnt == 3'd3))
                ptr <= OFFS_W'({addr_q[7:0], rx_byte});
            else if (prog_we || rd_adv)
                ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel  <= 1'b0;
            lock <= cfg_lock;
        end else if (busy_done) begin
            wel <= 1'b0;
        end else if (wren_go) begin
            wel <= 1'b1;
        end
    end

    sreg_busy #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_busy (
        .clk(clk), .rst(rst),
        .start_erase(erase_go), .start_prog(prog_go),
        .busy(wip), .done(busy_done)
    );

    sreg_array #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_array (
        .clk(clk),
        .erase_en(erase_go), .erase_sel(sel),
        .wr_en(prog_we), .wr_sel(sel), .wr_offs(ptr), .wr_data(rx_byte),
        .rd_sel(sel), .rd_offs(ptr), .rd_data(rd_data)
    );

endmodule

// File: rtl/sreg_ctrl_chk.sv
module sreg_ctrl_chk #(
    parameter int NUM_REGS = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                wip,
    input logic                wel,
    input logic                cs_rise,
    input logic [NUM_REGS-1:0] lock
);
    // R4: a busy period is only entered with the latch set
    a_r4_wel_before_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(wel));

    // R5: a busy period begins only right after a chip-select rise
    a_r5_start_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(wip) |-> $past(cs_rise));

    // R8: latch is clear when the busy period ends
    a_r8_wel_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(wip) |-> !wel);

    // R10: latch cannot change in the middle of a busy period
    a_r10_wel_frozen: assert property (@(posedge clk) disable iff (rst)
        (wip && $past(wip)) |-> $stable(wel));

    // R1: lock bits never change after reset
    a_r1_lock_fixed: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(lock));

endmodule

bind sreg_ctrl sreg_ctrl_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst(rst), .wip(wip), .wel(wel), .cs_rise(cs_rise), .lock(lock)
);

// File: tb/sreg_ctrl_tb.sv
module sreg_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int ERASE_N    = 1500;
    localparam int PROG_N     = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_lock = 3'b000;
    logic       spi_csn = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso;

    int checks = 0;
    int fails  = 0;

    logic [7:0] model [3][1024];
    logic [7:0] pbuf [8];
    logic [7:0] rbuf [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_ctrl #(.NUM_REGS(3), .ERASE_CYC(ERASE_N), .PROG_CYC(PROG_N)) u_dut (
        .clk(clk), .rst(rst), .cfg_lock(cfg_lock),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] lk);
        @(posedge clk); #1;
        rst = 1'b1; cfg_lock = lk; spi_csn = 1'b1; spi_sck = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic cs_lo();
        spi_csn = 1'b0;
        repeat (HALF) @(posedge clk);
        #1;
    endtask

    task automatic cs_hi();
        repeat (HALF) @(posedge clk);
        #1 spi_csn = 1'b1;
        repeat (2*HALF) @(posedge clk);
        #1;
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(posedge clk);
            #1 rx[i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(posedge clk);
            #1 spi_sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] d;
        xfer(op, d);
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    task automatic wren();
        logic [7:0] d;
        cs_lo(); xfer(8'h06, d); cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_lo(); xfer(8'h05, d); xfer(8'h00, s); cs_hi();
    endtask

    task automatic erase(input logic [23:0] a);
        cs_lo(); send_hdr(8'h44, a); cs_hi();
    endtask

    task automatic prog(input logic [23:0] a, input int n);
        logic [7:0] d;
        cs_lo(); send_hdr(8'h42, a);
        for (int i = 0; i < n; i++) xfer(pbuf[i], d);
        cs_hi();
    endtask

    task automatic rd(input logic [23:0] a, input int n);
        cs_lo(); send_hdr(8'h48, a);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        cs_hi();
    endtask

    task automatic status_is(input string req, input int exp);
        logic [7:0] s;
        rdsr(s);
        chk(req, s, exp);
    endtask

    task automatic read_vs_model(input string req, input int r, input int offs, input int n);
        rd({8'h00, 4'(r), 2'b00, 10'(offs)}, n);
        for (int i = 0; i < n; i++)
            chk(req, rbuf[i], model[r-1][(offs + i) % 1024]);
    endtask

    task automatic model_erase(input int r);
        for (int i = 0; i < 1024; i++) model[r-1][i] = 8'hFF;
    endtask

    task automatic model_prog(input int r, input int offs, input int n);
        for (int i = 0; i < n; i++)
            model[r-1][(offs + i) % 1024] = model[r-1][(offs + i) % 1024] & pbuf[i];
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        do_reset(3'b000);
        status_is("R1 reset status", 8'h00);

        erase(24'h001000);
        status_is("R4 erase without latch", 8'h00);

        wren();
        status_is("R2 latch set", 8'h02);

        // Sweep over all three registers: erase, program, read back.
        for (int r = 1; r <= 3; r++) begin
            int base;
            base = r * 211;
            wren();
            erase({8'h00, 4'(r), 12'h000});
            status_is("R8 busy after erase", 8'h03);
            wait_cyc(ERASE_N + 50);
            status_is("R8 idle and latch cleared after erase", 8'h00);
            model_erase(r);
            read_vs_model("R6 erased bank", r, 1020, 6);
            wren();
            for (int k = 0; k < 4; k++) pbuf[k] = 8'((r * 53 + k * 29) ^ 8'h5A);
            prog({8'h00, 4'(r), 2'b00, 10'(base)}, 4);
            status_is("R8 busy after program", 8'h03);
            wait_cyc(PROG_N + 50);
            status_is("R8 idle after program", 8'h00);
            model_prog(r, base, 4);
            read_vs_model("R7 programmed bytes", r, base - 1, 6);
        end

        // Second program ANDs into existing data.
        wren();
        pbuf[0] = 8'h0F; pbuf[1] = 8'hF0;
        prog({8'h00, 4'd1, 2'b00, 10'd212}, 2);
        wait_cyc(PROG_N + 50);
        model_prog(1, 212, 2);
        read_vs_model("R7 AND merge", 1, 211, 4);

        // Offset wrap for program and read.
        wren();
        pbuf[0] = 8'h11; pbuf[1] = 8'h22; pbuf[2] = 8'h33;
        prog({8'h00, 4'd2, 2'b00, 10'd1022}, 3);
        wait_cyc(PROG_N + 50);
        model_prog(2, 1022, 3);
        read_vs_model("R11 wrapped read of R7 wrapped program", 2, 1022, 4);

        // Program without latch.
        pbuf[0] = 8'h00;
        prog(24'h003000, 1);
        status_is("R4 program without latch", 8'h00);
        read_vs_model("R4 bank untouched", 3, 0, 1);

        // Invalid addresses.
        wren();
        erase(24'h004000);
        status_is("R3 bad select", 8'h02);
        erase(24'h011000);
        status_is("R3 high byte set", 8'h02);
        erase(24'h001400);
        status_is("R3 bit 10 set", 8'h02);
        prog(24'h000000, 1);
        status_is("R3 select zero", 8'h02);
        rd(24'h004000, 1);
        chk("R11 invalid address read", rbuf[0], 8'h00);

        // Erase aborted off a byte boundary, and with an extra byte.
        cs_lo(); send_hdr(8'h44, 24'h001000); xbits(8'hFF, 3, d); cs_hi();
        status_is("R5 erase mid-byte discarded", 8'h02);
        cs_lo(); send_hdr(8'h44, 24'h001000); xfer(8'h00, d); cs_hi();
        status_is("R5 erase with extra byte discarded", 8'h02);
        read_vs_model("R5 bank kept", 1, 211, 3);

        // Program with a trailing partial byte.
        cs_lo(); send_hdr(8'h42, 24'h001000 | 24'd600);
        xfer(8'hC3, d); xbits(8'h00, 4, d); cs_hi();
        status_is("R7 program with partial byte runs", 8'h03);
        wait_cyc(PROG_N + 50);
        pbuf[0] = 8'hC3;
        model_prog(1, 600, 1);
        read_vs_model("R7 partial byte dropped", 1, 600, 2);

        // Commands while busy.
        wren();
        erase(24'h003000);
        wren();
        pbuf[0] = 8'h00;
        prog(24'h003000, 1);
        rd(24'h003000, 1);
        chk("R10 read while busy", rbuf[0], 8'h00);
        wait_cyc(ERASE_N + 50);
        status_is("R10 latch not set while busy", 8'h00);
        model_erase(3);
        read_vs_model("R10 program while busy ignored", 3, 0, 1);

        // Locked registers 1 and 3.
        do_reset(3'b101);
        status_is("R1 status after second reset", 8'h00);
        wren();
        erase(24'h001000);
        status_is("R9 locked erase ignored", 8'h02);
        read_vs_model("R9 locked bank kept", 1, 211, 3);
        pbuf[0] = 8'h00;
        prog(24'h003000, 1);
        status_is("R9 locked program ignored", 8'h02);
        erase(24'h002000);
        status_is("R9 unlocked bank erases", 8'h03);
        wait_cyc(ERASE_N + 50);
        model_erase(2);
        read_vs_model("R6 unlocked bank erased", 2, 1022, 2);
        status_is("R8 latch cleared", 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule